// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This peripheral watches for a stalled program. A binary counter advances on one of two clock enables: a fast system tick or a slow subclock tick. If software does not restart the counter before it reaches the selected span, the block emits a one-cycle overflow event. A mode bit chooses whether that event appears as a reset pulse or as a non-maskable interrupt strobe. Four spans are available per clock source, each a factor of four shorter than the previous one.

Software restarts the count by writing a clear key (4Eh) to the command register. The watchdog cannot be switched off by a single write. It is disabled only when three writes occur in order: the clear key, a control write that leaves the enable bit at 0, and then the disable key (B1h). While disabled, the counter is held at zero. A later control write with the enable bit set starts a fresh count.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is running in reset mode with the longest fast-tick span. With the fast tick high every cycle, `wdt_reset` pulses after 2^FAST_EXP_MAX ticks, and `wdt_nmi` stays low.
- R2: The control register sits at address 0. Its bit fields are: bit 0 enable, bit 1 action (1 = reset, 0 = interrupt), bits 3:2 span select, bit 4 source (0 = fast, 1 = slow). With the fast source, select value s gives a span of 2^(FAST_EXP_MAX-2s) fast ticks.
- R3: With the slow source, select value s gives a span of 2^(SLOW_EXP_MAX-2s) slow ticks. The fast tick has no effect on the count.
- R4: A command write (address 1) of 4Eh clears the counter. The next overflow comes a full span after that write.
- R5: The sequence command 4Eh, then a control write with bit 0 = 0, then command B1h disables the watchdog. After it, no overflow event occurs.
- R6: Any command write other than 4Eh between the clear key and the disable key cancels the sequence. A B1h write that has no preceding 4Eh is also ignored. In both cases the watchdog keeps running.
- R7: A B1h write after 4Eh has no effect while the enable bit is 1.
- R8: With action bit 0, an overflow produces a one-cycle `wdt_nmi` strobe and no reset pulse. With action bit 1, it produces a one-cycle `wdt_reset` pulse and no strobe.
- R9: After each overflow the counter restarts from zero, so undisturbed events repeat exactly one span apart.
- R10: A control write that changes the span select or the source clears the counter.
- R11: While disabled the counter is held at zero. A control write with bit 0 = 1 restarts it, and the first overflow follows a full span later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_en | input | 1 | Fast-source count enable |
| slow_en | input | 1 | Slow-source count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control, 1 = command |
| bus_wdata | input | 8 | Write data |
| wdt_reset | output | 1 | One-cycle reset pulse on overflow |
| wdt_nmi | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The hardest state to reach is an armed disable sequence that is then broken. To reach it, the stimulus must place exact command and control writes in sequence, both with the enable bit clear and with it set. After each such sequence, the bench decides whether the watchdog is still alive by watching for a later overflow. Slow-source spans are also awkward: the slow enable runs at a fixed phase that is unrelated to the writes. For that reason, the bench counts the slow enables it actually presents rather than counting clock cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KEY_CLEAR = 8'h4E;
  localparam logic [7:0] KEY_OFF   = 8'hB1;

  typedef struct packed {
    logic       slow_src;
    logic [1:0] span_sel;
    logic       act_reset;
    logic       en;
  } wdt_ctrl_t;

  localparam wdt_ctrl_t CTRL_INIT = '{slow_src: 1'b0, span_sel: 2'd0, act_reset: 1'b1, en: 1'b1};

  // exponent of the span in ticks: each select step divides by four
  function automatic int unsigned span_exp(int unsigned max_exp, logic [1:0] sel);
    return max_exp - 2 * int'(sel);
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output wdt_ctrl_t  ctrl,
  output logic       run,
  output logic       cnt_clr
);
  logic      ctrl_wr, cmd_wr, armed, off;
  logic      key_clear_hit, key_off_hit, cfg_change, start_hit;
  wdt_ctrl_t ctrl_new;

  assign ctrl_wr  = bus_wr && !bus_addr;
  assign cmd_wr   = bus_wr && bus_addr;
  assign ctrl_new = wdt_ctrl_t'(bus_wdata[4:0]);

  assign key_clear_hit = cmd_wr && (bus_wdata == KEY_CLEAR);
  assign key_off_hit   = cmd_wr && (bus_wdata == KEY_OFF) && armed && !ctrl.en;
  assign cfg_change    = ctrl_wr && ((ctrl_new.span_sel != ctrl.span_sel) ||
                                     (ctrl_new.slow_src != ctrl.slow_src));
  assign start_hit     = ctrl_wr && ctrl_new.en && off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= CTRL_INIT;
      armed <= 1'b0;
      off   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_new;
      if (cmd_wr)  armed <= key_clear_hit;
      if (key_off_hit)      off <= 1'b1;
      else if (start_hit)   off <= 1'b0;
    end
  end

  assign run     = !off;
  assign cnt_clr = key_clear_hit || cfg_change || start_hit;

  AST_OFF_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off) |-> $past(cmd_wr && bus_wdata == KEY_OFF)); // R5
  AST_OFF_WITH_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !ctrl.en); // R7
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned FAST_EXP_MAX = 25,
  parameter int unsigned SLOW_EXP_MAX = 17,
  localparam int unsigned CNT_W = (FAST_EXP_MAX > SLOW_EXP_MAX) ? FAST_EXP_MAX : SLOW_EXP_MAX
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fast_en,
  input  logic      slow_en,
  input  wdt_ctrl_t ctrl,
  input  logic      run,
  input  logic      cnt_clr,
  output logic      ovf
);
  logic [CNT_W-1:0] cnt, last;
  logic             tick;
  int unsigned      exp_now;

  always_comb begin
    exp_now = ctrl.slow_src ? span_exp(SLOW_EXP_MAX, ctrl.span_sel)
                            : span_exp(FAST_EXP_MAX, ctrl.span_sel);
    last    = {CNT_W{1'b1}} >> (CNT_W - exp_now);
    tick    = ctrl.slow_src ? slow_en : fast_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (!run || cnt_clr) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == last) begin
          cnt <= '0;
          ovf <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0); // R11
  AST_OVF_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(run)); // R5
  AST_RESTART_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cnt == '0); // R9
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ovf,
  input  wdt_ctrl_t ctrl,
  output logic      wdt_reset,
  output logic      wdt_nmi
);
  assign wdt_reset = ovf && ctrl.act_reset;
  assign wdt_nmi   = ovf && !ctrl.act_reset;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_reset && wdt_nmi)); // R8
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset); // R8
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_nmi |=> !wdt_nmi); // R8
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned FAST_EXP_MAX = 25,
  parameter int unsigned SLOW_EXP_MAX = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_en,
  input  logic       slow_en,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic       wdt_reset,
  output logic       wdt_nmi
);
  wdt_ctrl_t ctrl;
  logic      run, cnt_clr, ovf;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl(ctrl), .run(run), .cnt_clr(cnt_clr)
  );

  wdt_counter #(.FAST_EXP_MAX(FAST_EXP_MAX), .SLOW_EXP_MAX(SLOW_EXP_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en),
    .ctrl(ctrl), .run(run), .cnt_clr(cnt_clr), .ovf(ovf)
  );

  wdt_action u_act (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .ctrl(ctrl),
    .wdt_reset(wdt_reset), .wdt_nmi(wdt_nmi)
  );

  AST_NO_EVENT_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && bus_wdata == KEY_CLEAR) |=> !(wdt_reset || wdt_nmi)); // R4
endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
  localparam int F = 8;
  localparam int S = 7;

  logic clk = 1'b0, rst_n = 1'b0, fast_en = 1'b1;
  logic bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic wdt_reset, wdt_nmi, slow_en;
  logic [1:0] slow_ph = 2'd0;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) slow_ph <= slow_ph + 2'd1;
  assign slow_en = (slow_ph == 2'd0);

  keyed_wdt #(.FAST_EXP_MAX(F), .SLOW_EXP_MAX(S)) u0 (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wdt_reset(wdt_reset), .wdt_nmi(wdt_nmi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit addr, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = addr; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] cfg(input bit en, input bit act, input int sel, input bit slow);
    return {3'b000, slow, sel[1:0], act, en};
  endfunction

  // counts edges (or slow enables) until the wanted output appears; -1 when none
  task automatic measure(input int limit, input bit want_nmi, input bit slow,
                         output int n, output bit other_seen);
    int ticks = 0;
    n = -1; other_seen = 1'b0;
    for (int k = 1; k <= limit; k++) begin
      if (slow_en) ticks++;
      @(posedge clk); @(negedge clk);
      if (want_nmi ? wdt_reset : wdt_nmi) other_seen = 1'b1;
      if (want_nmi ? wdt_nmi : wdt_reset) begin n = slow ? ticks : k; break; end
    end
  endtask

  task automatic quiet(input int cyc, output int events);
    events = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (wdt_reset || wdt_nmi) events++;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_run++;
    $display("FAIL watchdog: run hung");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, ev, exp;
    bit oth;
    repeat (3) @(negedge clk);
    check(!wdt_reset && !wdt_nmi, "R1 outputs idle in reset", int'(wdt_reset), 0);
    rst_n = 1'b1;
    measure(1000, 1'b0, 1'b0, n, oth);
    check(n == (1 << F) && !oth, "R1 default span", n, 1 << F);
    measure(1000, 1'b0, 1'b0, n, oth);
    check(n == (1 << F), "R9 repeat after overflow", n, 1 << F);

    for (int s = 0; s < 4; s++) begin
      exp = 1 << (F - 2 * s);
      wr(0, cfg(1, 1, s, 0));
      wr(1, 8'h4E);
      measure(1000, 1'b0, 1'b0, n, oth);
      check(n == exp && !oth, "R2 fast span", n, exp);
      measure(1000, 1'b0, 1'b0, n, oth);
      check(n == exp, "R9 periodic fast", n, exp);
    end

    for (int s = 0; s < 4; s++) begin
      exp = 1 << (S - 2 * s);
      wr(0, cfg(1, 1, s, 1));
      wr(1, 8'h4E);
      measure(1000, 1'b0, 1'b1, n, oth);
      check(n == exp && !oth, "R3 slow span", n, exp);
    end

    wr(0, cfg(1, 0, 2, 0));
    wr(1, 8'h4E);
    measure(1000, 1'b1, 1'b0, n, oth);
    check(n == 16 && !oth, "R8 nmi strobe, no reset", n, 16);
    @(negedge clk);
    check(!wdt_nmi, "R8 nmi one cycle", int'(wdt_nmi), 0);

    wr(0, cfg(1, 1, 1, 0));
    wr(1, 8'h4E);
    repeat (40) @(negedge clk);
    wr(1, 8'h4E);
    measure(1000, 1'b0, 1'b0, n, oth);
    check(n == 64, "R4 clear key restarts", n, 64);

    wr(0, cfg(1, 1, 2, 0));
    wr(1, 8'h4E);
    repeat (10) @(negedge clk);
    wr(0, cfg(1, 1, 1, 0));
    measure(1000, 1'b0, 1'b0, n, oth);
    check(n == 64, "R10 select change clears", n, 64);

    wr(0, cfg(1, 1, 2, 0));
    wr(1, 8'h4E);
    wr(0, cfg(0, 1, 2, 0));
    wr(1, 8'hB1);
    quiet(800, ev);
    check(ev == 0, "R5 disabled: no events", ev, 0);
    wr(0, cfg(1, 1, 2, 0));
    measure(1000, 1'b0, 1'b0, n, oth);
    check(n == 16, "R11 restart after disable full span", n, 16);

    wr(1, 8'h4E);
    wr(0, cfg(0, 1, 2, 0));
    wr(1, 8'h00);
    wr(1, 8'hB1);
    measure(40, 1'b0, 1'b0, n, oth);
    check(n > 0, "R6 broken sequence keeps running", n, 1);

    wr(0, cfg(0, 1, 2, 0));
    wr(1, 8'hB1);
    measure(40, 1'b0, 1'b0, n, oth);
    check(n > 0, "R6 disable key without clear key ignored", n, 1);

    wr(0, cfg(1, 1, 2, 0));
    wr(1, 8'h4E);
    wr(1, 8'hB1);
    measure(40, 1'b0, 1'b0, n, oth);
    check(n > 0, "R7 disable key with enable set ignored", n, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule